// File: doc/BRIEF.md
# Four-Stage Delayed-Branch Integer Pipeline

This block is a small in-order integer core for a register-to-register instruction set with one fixed 32-bit instruction format. It has four stages. Fetch presents the program counter. Register read decodes the instruction, reads the operands and resolves branches. Execute runs the ALU, writes ALU results back and forms load/store addresses. The memory stage performs the data access. Up to four instructions are in flight, and in steady state one instruction completes every cycle.

The core drives two ports of one dual-port memory: an instruction port and a data port. A fetch and a data access can therefore happen in the same cycle without stalling. Branches and jumps are delayed. The instruction right after a branch always executes, and there is no logic that squashes or kills instructions. Software fills an unusable delay slot with a NOOP. There is no operand forwarding, so software also spaces dependent instructions as stated below. Register file writes land at the end of the stage that produces the value.

The decoder uses these opcode states: NOP, ALU, ADDI, LOAD, STORE, BEQZ, BNEZ and JUMP. Any other opcode value decodes as NOP. Fetch has two transitions. Sequential fetch moves the PC on by 4. Redirect loads the branch target when a taken branch is in register read.

Top module: `dslot_core`

## Requirements
- R1: A synchronous active-high `rst` clears the PC to 0 and empties every stage. While in reset and in the first cycle after it, `i_addr` is 0 and `d_we` is 0. An in-flight store that is interrupted by reset never writes.
- R2: Field positions are opcode [31:28], rd [27:24], rs1 [23:20], rs2 [19:16] and imm [15:0]. The opcodes are 0 NOP, 1 ALU, 2 ADDI, 3 LOAD, 4 STORE, 5 BEQZ, 6 BNEZ and 7 JUMP. Opcodes 8 to 15 and the all-zero word change no register and no memory.
- R3: An ALU instruction writes rd with rs1 op rs2, where imm[2:0] selects the operation: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 signed less-than (result 1 or 0), 6 shift left by rs2[4:0], 7 logical shift right by rs2[4:0].
- R4: ADDI writes rd with rs1 plus the sign-extended imm.
- R5: LOAD writes rd from the word at byte address rs1 + sext(imm). STORE writes rs2 to that address. The address is formed in execute and the access is made in the following cycle on the data port.
- R6: Fetch and data access proceed in the same cycle. A run of N back-to-back stores asserts `d_we` in N consecutive cycles.
- R7: The instruction immediately after BEQZ, BNEZ or JUMP always executes, whether or not the branch is taken.
- R8: BEQZ is taken when rs1 is zero, BNEZ when rs1 is nonzero, and JUMP always. The target is (branch PC + 4) + sext(imm)*4. It is fetched right after the delay slot. A branch that is not taken continues sequentially.
- R9: An ALU or ADDI result is visible to the instruction two positions later. The very next instruction reads the old value. A loaded value is visible to the instruction three positions later.
- R10: When an ALU/ADDI in execute and a load in the memory stage write the same register in one cycle, the ALU/ADDI value is kept.
- R11: Register 0 always reads zero, and writes to it are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_addr | output | AW | Instruction fetch byte address (the PC) |
| i_rdata | input | 32 | Instruction word at `i_addr`, combinational |
| d_addr | output | AW | Data access byte address |
| d_re | output | 1 | Load access this cycle |
| d_we | output | 1 | Store write strobe this cycle |
| d_wdata | output | 32 | Store data |
| d_rdata | input | 32 | Data word at `d_addr`, combinational |

## Verification
The assertions assume that programs follow the software contract. No branch sits in another branch's delay slot, data addresses are word aligned, and memory answers both ports combinationally in the same cycle. The delay-slot and target checks compare the PC against the branch held in register read, so a branch placed in a delay slot would break them. Every program the stimulus loads obeys these rules: delay slots hold plain instructions or NOOPs, addresses are multiples of 4, and the bench memory model reads both ports asynchronously. Hazard spacing is stepped across the boundary on purpose, to observe the stale value.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

    localparam int XLEN  = 32;
    localparam int RW    = 4;
    localparam int NREG  = 1 << RW;
    localparam int IMM_W = 16;
    localparam int SH_W  = $clog2(XLEN);

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ALU   = 4'd1,
        OP_ADDI  = 4'd2,
        OP_LOAD  = 4'd3,
        OP_STORE = 4'd4,
        OP_BEQZ  = 4'd5,
        OP_BNEZ  = 4'd6,
        OP_JUMP  = 4'd7
    } opcode_e;

    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_SUB = 3'd1,
        FN_AND = 3'd2,
        FN_OR  = 3'd3,
        FN_XOR = 3'd4,
        FN_SLT = 3'd5,
        FN_SLL = 3'd6,
        FN_SRL = 3'd7
    } alufn_e;

    typedef struct packed {
        opcode_e          op;
        logic [RW-1:0]    rd;
        logic [RW-1:0]    rs1;
        logic [RW-1:0]    rs2;
        logic [IMM_W-1:0] imm;
    } instr_t;

    typedef struct packed {
        logic          wr_alu;
        logic          ld;
        logic          st;
        logic          br_z;
        logic          br_nz;
        logic          jmp;
        logic          use_imm;
        alufn_e        fn;
        logic [RW-1:0] rd;
    } ctl_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    // Opcode decode: unknown opcodes fall to the NOP state (R2)
    function automatic ctl_t decode(input instr_t ir);
        ctl_t c;
        c    = '0;
        c.fn = FN_ADD;
        c.rd = ir.rd;
        unique case (ir.op)
            OP_ALU: begin
                c.wr_alu = 1'b1;
                c.fn     = alufn_e'(ir.imm[2:0]);
            end
            OP_ADDI: begin
                c.wr_alu  = 1'b1;
                c.use_imm = 1'b1;
            end
            OP_LOAD: begin
                c.ld      = 1'b1;
                c.use_imm = 1'b1;
            end
            OP_STORE: begin
                c.st      = 1'b1;
                c.use_imm = 1'b1;
            end
            OP_BEQZ: c.br_z  = 1'b1;
            OP_BNEZ: c.br_nz = 1'b1;
            OP_JUMP: c.jmp   = 1'b1;
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dsp_fetch.sv
module dsp_fetch #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          redirect,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc
);

    localparam logic [AW-1:0] STEP = AW'(4);

    // Two transitions: sequential step or redirect to a branch target
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (redirect) begin
            pc <= target;
        end else begin
            pc <= pc + STEP;
        end
    end

endmodule

// File: rtl/dsp_alu.sv
module dsp_alu
    import dsp_pkg::*;
(
    input  alufn_e          fn,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    logic [SH_W-1:0] sh;
    assign sh = b[SH_W-1:0];

    always_comb begin
        unique case (fn)
            FN_ADD: y = a + b;
            FN_SUB: y = a - b;
            FN_AND: y = a & b;
            FN_OR:  y = a | b;
            FN_XOR: y = a ^ b;
            FN_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            FN_SLL: y = a << sh;
            FN_SRL: y = a >> sh;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/dsp_regfile.sv
module dsp_regfile
    import dsp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [RW-1:0]   ra1,
    input  logic [RW-1:0]   ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    input  logic            we_e,
    input  logic [RW-1:0]   wa_e,
    input  logic [XLEN-1:0] wd_e,
    input  logic            we_l,
    input  logic [RW-1:0]   wa_l,
    input  logic [XLEN-1:0] wd_l
);

    logic [NREG-1:0][XLEN-1:0] bank;

    assign bank[0] = '0;

    for (genvar i = 1; i < NREG; i++) begin : g_reg
        logic [XLEN-1:0] q;
        // Execute-stage port is younger, so it wins a same-register collision
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we_e && (wa_e == RW'(i))) begin
                q <= wd_e;
            end else if (we_l && (wa_l == RW'(i))) begin
                q <= wd_l;
            end
        end
        assign bank[i] = q;
    end

    assign rd1 = bank[ra1];
    assign rd2 = bank[ra2];

    AST_EX_WINS: assert property (@(posedge clk) disable iff (rst)
        (we_e && we_l && (wa_e == wa_l) && (wa_e != '0)) |=> (bank[$past(wa_e)] == $past(wd_e))); // R10

    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we_l && !(we_e && (wa_e == wa_l)) && (wa_l != '0)) |=> (bank[$past(wa_l)] == $past(wd_l))); // R5

endmodule

// File: rtl/dslot_core.sv
module dslot_core
    import dsp_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic            clk,
    input  logic            rst,
    output logic [AW-1:0]   i_addr,
    input  logic [XLEN-1:0] i_rdata,
    output logic [AW-1:0]   d_addr,
    output logic            d_re,
    output logic            d_we,
    output logic [XLEN-1:0] d_wdata,
    input  logic [XLEN-1:0] d_rdata
);

    localparam logic [AW-1:0] STEP = AW'(4);

    // Fetch
    logic [AW-1:0] pc;
    logic          redirect;
    logic [AW-1:0] target;

    // Register-read stage
    logic            r_v;
    logic [AW-1:0]   r_pc;
    instr_t          r_ir;
    ctl_t            r_ctl;
    logic [XLEN-1:0] rv1, rv2;
    logic [AW-1:0]   r_off;

    // Execute stage
    logic            x_v;
    logic            x_wr, x_ld, x_st;
    alufn_e          x_fn;
    logic [RW-1:0]   x_rd;
    logic [XLEN-1:0] x_a, x_b, x_sd;
    logic [XLEN-1:0] alu_y;

    // Memory stage
    logic            m_v;
    logic            m_ld, m_st;
    logic [RW-1:0]   m_rd;
    logic [AW-1:0]   m_addr;
    logic [XLEN-1:0] m_sd;

    dsp_fetch #(.AW(AW)) u_fetch (
        .clk      (clk),
        .rst      (rst),
        .redirect (redirect),
        .target   (target),
        .pc       (pc)
    );

    assign i_addr = pc;

    // Decode and branch resolution in register read
    always_comb begin
        r_ctl    = decode(r_ir);
        r_off    = AW'({sext_imm(r_ir.imm), 2'b00});
        target   = r_pc + STEP + r_off;
        redirect = r_v && (r_ctl.jmp ||
                           (r_ctl.br_z  && (rv1 == '0)) ||
                           (r_ctl.br_nz && (rv1 != '0)));
    end

    dsp_regfile u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra1  (r_ir.rs1),
        .ra2  (r_ir.rs2),
        .rd1  (rv1),
        .rd2  (rv2),
        .we_e (x_v && x_wr),
        .wa_e (x_rd),
        .wd_e (alu_y),
        .we_l (m_ld),
        .wa_l (m_rd),
        .wd_l (d_rdata)
    );

    dsp_alu u_alu (
        .fn (x_fn),
        .a  (x_a),
        .b  (x_b),
        .y  (alu_y)
    );

    // Stage registers
    always_ff @(posedge clk) begin
        if (rst) begin
            r_v    <= 1'b0;
            r_pc   <= '0;
            r_ir   <= '0;
            x_v    <= 1'b0;
            x_wr   <= 1'b0;
            x_ld   <= 1'b0;
            x_st   <= 1'b0;
            x_fn   <= FN_ADD;
            x_rd   <= '0;
            x_a    <= '0;
            x_b    <= '0;
            x_sd   <= '0;
            m_v    <= 1'b0;
            m_ld   <= 1'b0;
            m_st   <= 1'b0;
            m_rd   <= '0;
            m_addr <= '0;
            m_sd   <= '0;
        end else begin
            r_v    <= 1'b1;
            r_pc   <= pc;
            r_ir   <= instr_t'(i_rdata);
            x_v    <= r_v;
            x_wr   <= r_ctl.wr_alu;
            x_ld   <= r_ctl.ld;
            x_st   <= r_ctl.st;
            x_fn   <= r_ctl.fn;
            x_rd   <= r_ctl.rd;
            x_a    <= rv1;
            x_b    <= r_ctl.use_imm ? sext_imm(r_ir.imm) : rv2;
            x_sd   <= rv2;
            m_v    <= x_v;
            m_ld   <= x_v && x_ld;
            m_st   <= x_v && x_st;
            m_rd   <= x_rd;
            m_addr <= alu_y[AW-1:0];
            m_sd   <= x_sd;
        end
    end

    assign d_addr  = m_addr;
    assign d_re    = m_ld;
    assign d_we    = m_st;
    assign d_wdata = m_sd;

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((i_addr == '0) && !d_we && !d_re)); // R1

    AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        x_v |=> m_v); // R6

    AST_DATA_PORT_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({d_re, d_we})); // R5

    AST_SLOT_FETCHED: assert property (@(posedge clk) disable iff (rst)
        (r_v && (r_ctl.jmp || r_ctl.br_z || r_ctl.br_nz)) |-> (pc == r_pc + STEP)); // R7

    AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (pc == $past(target))); // R8

    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (r_v && (r_ctl.br_z || r_ctl.br_nz) && !redirect) |=> (pc == $past(pc) + STEP)); // R8

endmodule

// File: tb/sim_dslot_core.sv
`timescale 1ns/1ps
module sim_dslot_core;
    import dsp_pkg::*;

    localparam int AW = 12;
    localparam int MW = 1 << (AW - 2);
    localparam int NV = 9;
    // {fn[2:0], a[31:0], b[31:0], expected[31:0]}
    localparam logic [98:0] VEC [NV] = '{
        {3'd0, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C},
        {3'd1, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE},
        {3'd2, 32'hF0F0_1234, 32'h0FF0_FFFF, 32'h00F0_1234},
        {3'd3, 32'hF000_0000, 32'h0000_000F, 32'hF000_000F},
        {3'd4, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_0F0F},
        {3'd5, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},
        {3'd5, 32'h0000_0005, 32'hFFFF_FFFE, 32'h0000_0000},
        {3'd6, 32'h0000_0001, 32'h0000_0024, 32'h0000_0010},
        {3'd7, 32'h8000_0000, 32'h0000_001F, 32'h0000_0001}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [AW-1:0]   i_addr, d_addr;
    logic [31:0]     i_rdata, d_rdata, d_wdata;
    logic            d_re, d_we;
    logic [31:0]     mem [MW];

    int n_chk = 0;
    int n_err = 0;
    int run_len = 0;
    int max_run = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dslot_core #(.AW(AW)) u0 (
        .clk     (clk),
        .rst     (rst),
        .i_addr  (i_addr),
        .i_rdata (i_rdata),
        .d_addr  (d_addr),
        .d_re    (d_re),
        .d_we    (d_we),
        .d_wdata (d_wdata),
        .d_rdata (d_rdata)
    );

    assign i_rdata = mem[i_addr[AW-1:2]];
    assign d_rdata = mem[d_addr[AW-1:2]];

    always @(posedge clk) begin
        if (d_we) mem[d_addr[AW-1:2]] <= d_wdata;
    end

    always @(negedge clk) begin
        if (d_we) begin
            run_len = run_len + 1;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] rd,
                                        input logic [3:0] rs1, input logic [3:0] rs2,
                                        input logic [15:0] imm);
        return {op, rd, rs1, rs2, imm};
    endfunction

    function automatic logic [31:0] word_at(input int byte_addr);
        return mem[byte_addr / 4];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wipe();
        for (int k = 0; k < MW; k++) mem[k] = '0;
    endtask

    task automatic boot_and_run(input int n);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        wipe();
        // R1: reset state at the ports
        @(negedge clk);
        chk("R1 fetch address in reset", {20'd0, i_addr}, 32'd0);
        chk("R1 no store in reset", {31'd0, d_we}, 32'd0);

        // R3 table: load two operands, ALU op, store result
        for (int v = 0; v < NV; v++) begin
            wipe();
            mem[32'h400 / 4] = VEC[v][95:64];
            mem[32'h404 / 4] = VEC[v][63:32];
            mem[0] = enc(4'd3, 4'd1, 4'd0, 4'd0, 16'h0400);
            mem[1] = enc(4'd3, 4'd2, 4'd0, 4'd0, 16'h0404);
            mem[4] = enc(4'd1, 4'd3, 4'd1, 4'd2, {13'd0, VEC[v][98:96]});
            mem[6] = enc(4'd4, 4'd0, 4'd0, 4'd3, 16'h0408);
            boot_and_run(16);
            chk($sformatf("R3 alu vector %0d", v), word_at(32'h408), VEC[v][31:0]);
        end

        // Hazard spacing, write collision, r0, unknown opcode, ADDI, addressing
        wipe();
        mem[32'h400 / 4] = 32'hAAAA_5555;
        mem[32'h70C / 4] = 32'hDEAD_BEEF;
        mem[32'h710 / 4] = 32'h1111_1111;
        mem[0]  = enc(4'd2, 4'd1, 4'd0, 4'd0, 16'd7);
        mem[1]  = enc(4'd2, 4'd2, 4'd1, 4'd0, 16'd1);
        mem[2]  = enc(4'd2, 4'd3, 4'd1, 4'd0, 16'd1);
        mem[3]  = enc(4'd3, 4'd6, 4'd0, 4'd0, 16'h0400);
        mem[4]  = enc(4'd2, 4'd6, 4'd0, 4'd0, 16'd9);
        mem[5]  = enc(4'd2, 4'd0, 4'd0, 4'd0, 16'd5);
        mem[6]  = enc(4'hF, 4'd7, 4'd1, 4'd1, 16'h1234);
        mem[9]  = enc(4'd4, 4'd0, 4'd0, 4'd2, 16'h0700);
        mem[10] = enc(4'd4, 4'd0, 4'd0, 4'd3, 16'h0704);
        mem[11] = enc(4'd4, 4'd0, 4'd0, 4'd6, 16'h0708);
        mem[12] = enc(4'd4, 4'd0, 4'd0, 4'd0, 16'h070C);
        mem[13] = enc(4'd4, 4'd0, 4'd0, 4'd7, 16'h0710);
        mem[14] = enc(4'd3, 4'd8, 4'd0, 4'd0, 16'h0400);
        mem[17] = enc(4'd2, 4'd9, 4'd8, 4'd0, 16'd1);
        mem[19] = enc(4'd4, 4'd0, 4'd0, 4'd9, 16'h0714);
        mem[20] = enc(4'd2, 4'd11, 4'd0, 4'd0, 16'h0720);
        mem[21] = enc(4'd2, 4'd10, 4'd0, 4'd0, 16'hFFFD);
        mem[23] = enc(4'd4, 4'd0, 4'd11, 4'd10, 16'hFFFC);
        boot_and_run(40);
        chk("R9 adjacent reader sees old value", word_at(32'h700), 32'd1);
        chk("R9 reader two later sees new value", word_at(32'h704), 32'd8);
        chk("R10 execute write beats load write", word_at(32'h708), 32'd9);
        chk("R11 register zero ignores writes", word_at(32'h70C), 32'd0);
        chk("R2 unknown opcode leaves rd untouched", word_at(32'h710), 32'd0);
        chk("R9 load visible three later", word_at(32'h714), 32'hAAAA_5556);
        chk("R4 R5 negative imm and offset", word_at(32'h71C), 32'hFFFF_FFFD);

        // Conditional branches and delay slots
        wipe();
        mem[0]  = enc(4'd2, 4'd1, 4'd0, 4'd0, 16'd3);
        mem[2]  = enc(4'd5, 4'd0, 4'd1, 4'd0, 16'd4);
        mem[3]  = enc(4'd2, 4'd2, 4'd0, 4'd0, 16'd1);
        mem[4]  = enc(4'd2, 4'd3, 4'd0, 4'd0, 16'd2);
        mem[5]  = enc(4'd6, 4'd0, 4'd1, 4'd0, 16'd2);
        mem[6]  = enc(4'd2, 4'd4, 4'd0, 4'd0, 16'd4);
        mem[7]  = enc(4'd2, 4'd5, 4'd0, 4'd0, 16'd5);
        mem[8]  = enc(4'd5, 4'd0, 4'd0, 4'd0, 16'd1);
        mem[9]  = enc(4'd2, 4'd12, 4'd0, 4'd0, 16'd6);
        mem[10] = enc(4'd4, 4'd0, 4'd0, 4'd2, 16'h0600);
        mem[11] = enc(4'd4, 4'd0, 4'd0, 4'd3, 16'h0604);
        mem[12] = enc(4'd4, 4'd0, 4'd0, 4'd4, 16'h0608);
        mem[13] = enc(4'd4, 4'd0, 4'd0, 4'd5, 16'h060C);
        mem[14] = enc(4'd4, 4'd0, 4'd0, 4'd12, 16'h0610);
        boot_and_run(30);
        chk("R7 slot after untaken BEQZ runs", word_at(32'h600), 32'd1);
        chk("R8 untaken BEQZ falls through", word_at(32'h604), 32'd2);
        chk("R7 slot after taken BNEZ runs", word_at(32'h608), 32'd4);
        chk("R8 taken BNEZ skips to target", word_at(32'h60C), 32'd0);
        chk("R7 slot after taken BEQZ runs", word_at(32'h610), 32'd6);

        // Unconditional jump
        wipe();
        mem[1] = enc(4'd7, 4'd0, 4'd0, 4'd0, 16'd3);
        mem[2] = enc(4'd2, 4'd4, 4'd0, 4'd0, 16'd11);
        mem[3] = enc(4'd2, 4'd5, 4'd0, 4'd0, 16'd22);
        mem[4] = enc(4'd2, 4'd5, 4'd0, 4'd0, 16'd33);
        mem[6] = enc(4'd4, 4'd0, 4'd0, 4'd4, 16'h0620);
        mem[7] = enc(4'd4, 4'd0, 4'd0, 4'd5, 16'h0624);
        boot_and_run(20);
        chk("R7 jump delay slot executes", word_at(32'h620), 32'd11);
        chk("R8 jump skips to target", word_at(32'h624), 32'd0);

        // Back-to-back stores: one completes per cycle
        wipe();
        for (int k = 0; k < 4; k++) begin
            mem[(32'h500 / 4) + k] = 32'hFFFF_FFFF;
            mem[k] = enc(4'd4, 4'd0, 4'd0, 4'd0, 16'(32'h500 + 4 * k));
        end
        max_run = 0;
        boot_and_run(14);
        chk("R6 consecutive store strobes", max_run, 32'd4);
        chk("R6 last store written", word_at(32'h50C), 32'd0);

        // Reset while a store is in flight
        wipe();
        mem[32'h500 / 4] = 32'hFFFF_FFFF;
        mem[0] = enc(4'd4, 4'd0, 4'd0, 4'd0, 16'h0500);
        boot_and_run(2);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 fetch address after mid-run reset", {20'd0, i_addr}, 32'd0);
        chk("R1 no store strobe after reset", {31'd0, d_we}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R1 in-flight store dropped", word_at(32'h500), 32'hFFFF_FFFF);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule